// File: doc/BRIEF.md
# Character Cell Video Timing Generator

This block derives every raster timing signal of a text-mode display from one free-running dot clock. A dot divider produces a character clock whose period is 10 dots in the narrow format (80 columns) or 6 dots in the wide format (132 columns). It also produces a processor clock that always divides by 6, and a strobe that tells the dot serializer when to take the next glyph pattern. A horizontal counter and a vertical counter then place sync pulses and blanking, track the character row and the scan line within it, and request a memory fetch ahead of every new character row.

Two select inputs choose the column format and the refresh rate. The divide ratio, the line length and the frame length follow them, so that one fixed dot clock serves all four formats. The selects are captured while reset is held and again only on the last dot of a frame, so a format change never produces a short or torn line. With the default parameters, 25 rows of 12 scan lines give 300 visible lines, inside a 319-line frame (fast rate) or a 383-line frame (slow rate).

Top module: `vtg_top`

## Requirements
- R1: The character clock `char_clk` has a period of 10 dot clocks when `sel_wide` is 0 and 6 when it is 1. It is high for the first half of each character time. `load_stb` is high for exactly one dot clock, on the last dot of every character time.
- R2: `proc_clk` has a period of 6 dot clocks in every format and is high for its first 3. Its phase runs on from reset without regard to line or frame boundaries.
- R3: A line lasts 97 character times with the first 80 visible when `sel_wide` is 0, and 154 with the first 132 visible when it is 1. `blank` is high in every non-visible character time.
- R4: `hsync` starts 4 character times after the visible part of a line and lasts 8 in the narrow format. In the wide format it starts after 6 and lasts 10. It is never high while a visible character is shown.
- R5: A frame has 300 visible lines (25 rows of 12 scan lines) out of 319 lines when `sel_slow` is 0 and 383 lines when it is 1. `blank` is high on every line after the visible ones.
- R6: `vsync` covers 4 whole lines. It starts 5 lines after the last visible line at the fast rate (`sel_slow`=0) and 37 lines after it at the slow rate (`sel_slow`=1).
- R7: `row` (0 to 24) and `scan` (0 to 11) give the position of the current visible line. They hold 24 and 11 through vertical blanking and return to 0 when the frame wraps. `first_scan` is high on every visible line whose scan index is 0.
- R8: `fetch_req` is high exactly during `hsync` of the line that comes before the first scan line of each row. That line is the last scan line of the previous row, or the last line of the frame before row 0. This gives 25 requests per frame.
- R9: `sel_wide` and `sel_slow` are sampled while `rst` is high and on the final dot of a frame, and at no other time. A change in the middle of a frame leaves that frame's timing untouched and takes effect from the next frame.
- R10: `rst` is synchronous and active high. While it is held and right after it is released, the position is dot 0 of character 0 of line 0. In that state `hsync`, `vsync`, `blank`, `load_stb` and `fetch_req` are 0, `row` and `scan` are 0, and `first_scan`, `char_clk` and `proc_clk` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_wide | input | 1 | 1 selects the 132-column format, 0 the 80-column format |
| sel_slow | input | 1 | 1 selects the 50 Hz frame, 0 the 60 Hz frame |
| char_clk | output | 1 | Character clock, high in the first half of each character time |
| load_stb | output | 1 | One-dot strobe on the last dot of each character time |
| proc_clk | output | 1 | Processor clock, dot clock divided by 6 |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | High outside the visible area |
| row | output | 5 | Character row of the current visible line |
| scan | output | 4 | Scan line within the current row |
| first_scan | output | 1 | High on scan line 0 of a visible row |
| fetch_req | output | 1 | Memory fetch request for the next row |

## Verification
On every cycle, the bound checker confirms several invariants. Sync pulses fall only inside blanking, and the load strobe never lasts two dots. `row` and `scan` stay in range, and `first_scan` coincides with scan index 0. A fetch request occurs only within horizontal sync, and the latched format changes only on the edge that closes a frame. The exact sync offsets, the line and frame lengths, the hold of `row`/`scan` through blanking and the one-frame delay of a format change cannot be shown this way. The bench shows them by comparing every output, cycle by cycle, with a position model built from the requirements. It runs all four formats and a sequence of mid-frame format changes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // Display format latched at frame boundaries
    typedef struct packed {
        logic wide;   // 1: 132-column format
        logic slow;   // 1: 50 Hz frame
    } vtg_mode_t;

endpackage

// File: rtl/vtg_clkdiv.sv
module vtg_clkdiv #(
    parameter int DIV_NARROW = 10,
    parameter int DIV_WIDE   = 6,
    parameter int PROC_DIV   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic wide,
    output logic char_clk,
    output logic char_end,
    output logic proc_clk
);
    localparam int DMAX = (DIV_NARROW > DIV_WIDE) ? DIV_NARROW : DIV_WIDE;
    localparam int DW   = $clog2(DMAX);
    localparam int PW   = $clog2(PROC_DIV);

    typedef struct packed {
        logic [DW-1:0] dot;
        logic [PW-1:0] prc;
    } div_t;

    div_t d, q;
    logic [DW-1:0] last_dot;
    logic [DW-1:0] half_dot;

    always_comb begin
        last_dot = wide ? DW'(DIV_WIDE - 1) : DW'(DIV_NARROW - 1);
        half_dot = wide ? DW'(DIV_WIDE / 2) : DW'(DIV_NARROW / 2);
        d = q;
        d.dot = (q.dot == last_dot) ? '0 : q.dot + 1'b1;
        d.prc = (q.prc == PW'(PROC_DIV - 1)) ? '0 : q.prc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign char_end = (q.dot == last_dot);
    assign char_clk = (q.dot < half_dot);
    assign proc_clk = (q.prc < PW'(PROC_DIV / 2));
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
    parameter int ACT_A = 80,
    parameter int FP_A  = 4,
    parameter int SW_A  = 8,
    parameter int BP_A  = 5,
    parameter int ACT_B = 132,
    parameter int FP_B  = 6,
    parameter int SW_B  = 10,
    parameter int BP_B  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic sel_b,
    output logic last,
    output logic active,
    output logic sync
);
    localparam int TOT_A = ACT_A + FP_A + SW_A + BP_A;
    localparam int TOT_B = ACT_B + FP_B + SW_B + BP_B;
    localparam int TMAX  = (TOT_A > TOT_B) ? TOT_A : TOT_B;
    localparam int W     = $clog2(TMAX);

    typedef struct packed {
        logic [W-1:0] cnt;
    } axis_t;

    axis_t d, q;
    logic [W-1:0] tot_m1, act_n, sync_s, sync_e;

    always_comb begin
        tot_m1 = sel_b ? W'(TOT_B - 1)           : W'(TOT_A - 1);
        act_n  = sel_b ? W'(ACT_B)               : W'(ACT_A);
        sync_s = sel_b ? W'(ACT_B + FP_B)        : W'(ACT_A + FP_A);
        sync_e = sel_b ? W'(ACT_B + FP_B + SW_B) : W'(ACT_A + FP_A + SW_A);
        d = q;
        if (adv) d.cnt = (q.cnt == tot_m1) ? '0 : q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign last   = (q.cnt == tot_m1);
    assign active = (q.cnt < act_n);
    assign sync   = (q.cnt >= sync_s) && (q.cnt < sync_e);
endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
    parameter int DIV_NARROW    = 10,
    parameter int DIV_WIDE      = 6,
    parameter int PROC_DIV      = 6,
    parameter int H_ACT_NARROW  = 80,
    parameter int H_FP_NARROW   = 4,
    parameter int H_SYNC_NARROW = 8,
    parameter int H_BP_NARROW   = 5,
    parameter int H_ACT_WIDE    = 132,
    parameter int H_FP_WIDE     = 6,
    parameter int H_SYNC_WIDE   = 10,
    parameter int H_BP_WIDE     = 6,
    parameter int ROWS          = 25,
    parameter int SCANS         = 12,
    parameter int V_FP_FAST     = 5,
    parameter int V_SYNC_FAST   = 4,
    parameter int V_BP_FAST     = 10,
    parameter int V_FP_SLOW     = 37,
    parameter int V_SYNC_SLOW   = 4,
    parameter int V_BP_SLOW     = 42,
    localparam int RW  = (ROWS  > 1) ? $clog2(ROWS)  : 1,
    localparam int SCW = (SCANS > 1) ? $clog2(SCANS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel_wide,
    input  logic           sel_slow,
    output logic           char_clk,
    output logic           load_stb,
    output logic           proc_clk,
    output logic           hsync,
    output logic           vsync,
    output logic           blank,
    output logic [RW-1:0]  row,
    output logic [SCW-1:0] scan,
    output logic           first_scan,
    output logic           fetch_req
);
    localparam int V_ACT = ROWS * SCANS;

    typedef struct packed {
        vtg_pkg::vtg_mode_t mode;
        logic [RW-1:0]      row;
        logic [SCW-1:0]     scan;
    } top_t;

    top_t d, q;
    logic char_end, line_end, frame_end;
    logic h_last, h_act, v_last, v_act, last_scan, last_row;

    vtg_clkdiv #(
        .DIV_NARROW(DIV_NARROW), .DIV_WIDE(DIV_WIDE), .PROC_DIV(PROC_DIV)
    ) u_div (
        .clk(clk), .rst(rst), .wide(q.mode.wide),
        .char_clk(char_clk), .char_end(char_end), .proc_clk(proc_clk)
    );

    vtg_axis #(
        .ACT_A(H_ACT_NARROW), .FP_A(H_FP_NARROW), .SW_A(H_SYNC_NARROW), .BP_A(H_BP_NARROW),
        .ACT_B(H_ACT_WIDE),   .FP_B(H_FP_WIDE),   .SW_B(H_SYNC_WIDE),   .BP_B(H_BP_WIDE)
    ) u_h (
        .clk(clk), .rst(rst), .adv(char_end), .sel_b(q.mode.wide),
        .last(h_last), .active(h_act), .sync(hsync)
    );

    assign line_end = char_end & h_last;

    vtg_axis #(
        .ACT_A(V_ACT), .FP_A(V_FP_FAST), .SW_A(V_SYNC_FAST), .BP_A(V_BP_FAST),
        .ACT_B(V_ACT), .FP_B(V_FP_SLOW), .SW_B(V_SYNC_SLOW), .BP_B(V_BP_SLOW)
    ) u_v (
        .clk(clk), .rst(rst), .adv(line_end), .sel_b(q.mode.slow),
        .last(v_last), .active(v_act), .sync(vsync)
    );

    assign frame_end = line_end & v_last;
    assign last_scan = (q.scan == SCW'(SCANS - 1));
    assign last_row  = (q.row  == RW'(ROWS - 1));

    always_comb begin
        d = q;
        if (frame_end) begin
            d.mode.wide = sel_wide;
            d.mode.slow = sel_slow;
        end
        if (line_end) begin
            if (v_last) begin
                d.row  = '0;
                d.scan = '0;
            end else if (v_act) begin
                if (!last_scan) begin
                    d.scan = q.scan + 1'b1;
                end else if (!last_row) begin
                    d.scan = '0;
                    d.row  = q.row + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.mode.wide <= sel_wide;
            q.mode.slow <= sel_slow;
            q.row       <= '0;
            q.scan      <= '0;
        end else begin
            q <= d;
        end
    end

    assign load_stb   = char_end;
    assign blank      = ~(h_act & v_act);
    assign row        = q.row;
    assign scan       = q.scan;
    assign first_scan = v_act & (q.scan == '0);
    assign fetch_req  = hsync & (v_last | (v_act & last_scan & ~last_row));
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
    parameter int ROWS  = 25,
    parameter int SCANS = 12,
    parameter int RW    = 5,
    parameter int SCW   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               hsync,
    input logic               vsync,
    input logic               blank,
    input logic               load_stb,
    input logic               first_scan,
    input logic               fetch_req,
    input logic [RW-1:0]      row,
    input logic [SCW-1:0]     scan,
    input vtg_pkg::vtg_mode_t mode_q,
    input logic               frame_end
);
    assert_load_single_R1: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !load_stb);

    assert_hsync_blank_R4: assert property (@(posedge clk) disable iff (rst)
        hsync |-> blank);

    assert_vsync_blank_R6: assert property (@(posedge clk) disable iff (rst)
        vsync |-> blank);

    assert_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(scan) < SCANS) && (int'(row) < ROWS));

    assert_first_scan_R7: assert property (@(posedge clk) disable iff (rst)
        first_scan |-> (scan == '0));

    assert_fetch_hsync_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> hsync);

    assert_mode_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mode_q) && !$past(rst)) |-> $past(frame_end));
endmodule

bind vtg_top vtg_chk #(.ROWS(ROWS), .SCANS(SCANS), .RW(RW), .SCW(SCW)) u_chk (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .blank(blank),
    .load_stb(load_stb), .first_scan(first_scan), .fetch_req(fetch_req),
    .row(row), .scan(scan), .mode_q(q.mode), .frame_end(frame_end)
);

// File: tb/tb_vtg_top.sv
`timescale 1ns/1ps
module tb_vtg_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    // configuration 0: default instance, configuration 1: reduced instance
    localparam int P_DN [2] = '{10, 4};
    localparam int P_DW [2] = '{6, 3};
    localparam int P_PD [2] = '{6, 3};
    localparam int P_HA [2][2] = '{'{80, 132}, '{6, 8}};
    localparam int P_HF [2][2] = '{'{4, 6},    '{1, 2}};
    localparam int P_HS [2][2] = '{'{8, 10},   '{2, 2}};
    localparam int P_HB [2][2] = '{'{5, 6},    '{1, 1}};
    localparam int P_R  [2] = '{25, 3};
    localparam int P_S  [2] = '{12, 2};
    localparam int P_VF [2][2] = '{'{5, 37},   '{1, 2}};
    localparam int P_VS [2][2] = '{'{4, 4},    '{1, 2}};
    localparam int P_VB [2][2] = '{'{10, 42},  '{1, 3}};

    // vector: wide, slow, dots per char, chars per line
    localparam int VEC [4][4] = '{'{0, 0, 10, 97}, '{1, 0, 6, 154},
                                  '{0, 1, 10, 97}, '{1, 1, 6, 154}};

    logic rst, m_wide, m_slow;
    logic d_cclk, d_ld, d_pclk, d_hs, d_vs, d_bl, d_fs, d_fr;
    logic [4:0] d_row;
    logic [3:0] d_scan;

    logic s_rst, s_wide, s_slow;
    logic s_cclk, s_ld, s_pclk, s_hs, s_vs, s_bl, s_fs, s_fr;
    logic [1:0] s_row;
    logic [0:0] s_scan;

    vtg_top dut (
        .clk(clk), .rst(rst), .sel_wide(m_wide), .sel_slow(m_slow),
        .char_clk(d_cclk), .load_stb(d_ld), .proc_clk(d_pclk), .hsync(d_hs),
        .vsync(d_vs), .blank(d_bl), .row(d_row), .scan(d_scan),
        .first_scan(d_fs), .fetch_req(d_fr)
    );

    vtg_top #(
        .DIV_NARROW(4), .DIV_WIDE(3), .PROC_DIV(3),
        .H_ACT_NARROW(6), .H_FP_NARROW(1), .H_SYNC_NARROW(2), .H_BP_NARROW(1),
        .H_ACT_WIDE(8), .H_FP_WIDE(2), .H_SYNC_WIDE(2), .H_BP_WIDE(1),
        .ROWS(3), .SCANS(2),
        .V_FP_FAST(1), .V_SYNC_FAST(1), .V_BP_FAST(1),
        .V_FP_SLOW(2), .V_SYNC_SLOW(2), .V_BP_SLOW(3)
    ) dut_small (
        .clk(clk), .rst(s_rst), .sel_wide(s_wide), .sel_slow(s_slow),
        .char_clk(s_cclk), .load_stb(s_ld), .proc_clk(s_pclk), .hsync(s_hs),
        .vsync(s_vs), .blank(s_bl), .row(s_row), .scan(s_scan),
        .first_scan(s_fs), .fetch_req(s_fr)
    );

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        int cclk; int ld; int pclk; int hs; int vs;
        int bl;   int row; int scan; int fs; int fr;
    } exp_t;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int frame_len(input int cfg, input int wide, input int slow);
        int div, ht, vt;
        div = wide ? P_DW[cfg] : P_DN[cfg];
        ht  = P_HA[cfg][wide] + P_HF[cfg][wide] + P_HS[cfg][wide] + P_HB[cfg][wide];
        vt  = P_R[cfg] * P_S[cfg] + P_VF[cfg][slow] + P_VS[cfg][slow] + P_VB[cfg][slow];
        return div * ht * vt;
    endfunction

    // c: dot clocks since frame start, t: dot clocks since reset release
    function automatic exp_t model(input int cfg, input int wide, input int slow,
                                   input int c, input int t);
        exp_t e;
        int div, ha, hss, hse, ht, vact, vss, vse, vt, h, v, vv;
        div  = wide ? P_DW[cfg] : P_DN[cfg];
        ha   = P_HA[cfg][wide];
        hss  = ha + P_HF[cfg][wide];
        hse  = hss + P_HS[cfg][wide];
        ht   = hse + P_HB[cfg][wide];
        vact = P_R[cfg] * P_S[cfg];
        vss  = vact + P_VF[cfg][slow];
        vse  = vss + P_VS[cfg][slow];
        vt   = vse + P_VB[cfg][slow];
        h    = (c / div) % ht;
        v    = (c / (div * ht)) % vt;
        vv   = (v < vact) ? v : vact - 1;
        e.cclk = ((c % div) < div / 2) ? 1 : 0;
        e.ld   = ((c % div) == div - 1) ? 1 : 0;
        e.pclk = ((t % P_PD[cfg]) < P_PD[cfg] / 2) ? 1 : 0;
        e.hs   = (h >= hss && h < hse) ? 1 : 0;
        e.vs   = (v >= vss && v < vse) ? 1 : 0;
        e.bl   = (h < ha && v < vact) ? 0 : 1;
        e.row  = vv / P_S[cfg];
        e.scan = vv % P_S[cfg];
        e.fs   = (v < vact && e.scan == 0) ? 1 : 0;
        e.fr   = (e.hs == 1 && (v == vt - 1 || (v < vact - 1 && e.scan == P_S[cfg] - 1))) ? 1 : 0;
        return e;
    endfunction

    task automatic cmp(input int cfg, input exp_t e);
        exp_t a;
        a.cclk = cfg ? int'(s_cclk) : int'(d_cclk);
        a.ld   = cfg ? int'(s_ld)   : int'(d_ld);
        a.pclk = cfg ? int'(s_pclk) : int'(d_pclk);
        a.hs   = cfg ? int'(s_hs)   : int'(d_hs);
        a.vs   = cfg ? int'(s_vs)   : int'(d_vs);
        a.bl   = cfg ? int'(s_bl)   : int'(d_bl);
        a.row  = cfg ? int'(s_row)  : int'(d_row);
        a.scan = cfg ? int'(s_scan) : int'(d_scan);
        a.fs   = cfg ? int'(s_fs)   : int'(d_fs);
        a.fr   = cfg ? int'(s_fr)   : int'(d_fr);
        chk("R1",    "char_clk",   a.cclk, e.cclk);
        chk("R1",    "load_stb",   a.ld,   e.ld);
        chk("R2",    "proc_clk",   a.pclk, e.pclk);
        chk("R4",    "hsync",      a.hs,   e.hs);
        chk("R6",    "vsync",      a.vs,   e.vs);
        chk("R3/R5", "blank",      a.bl,   e.bl);
        chk("R7",    "row",        a.row,  e.row);
        chk("R7",    "scan",       a.scan, e.scan);
        chk("R7",    "first_scan", a.fs,   e.fs);
        chk("R8",    "fetch_req",  a.fr,   e.fr);
    endtask

    task automatic restart_main(input int wide, input int slow);
        rst    = 1'b1;
        m_wide = wide[0];
        m_slow = slow[0];
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int held_w, held_s, fm_w, fm_s, fstart, fetch_rises;
        logic prev_fr;
        rst = 1'b1; m_wide = 1'b0; m_slow = 1'b0;
        s_rst = 1'b1; s_wide = 1'b0; s_slow = 1'b0;

        // R1 R2 R3 R4 R10: one line and a bit in each format
        for (int i = 0; i < 4; i++) begin
            int lds, first_ld, second_ld, line_dots;
            restart_main(VEC[i][0], VEC[i][1]);
            lds = 0; first_ld = -1; second_ld = -1;
            line_dots = VEC[i][2] * VEC[i][3];
            for (int c = 0; c <= line_dots + VEC[i][2]; c++) begin
                if (c > 0) begin @(posedge clk); #1; end
                cmp(0, model(0, VEC[i][0], VEC[i][1], c, c));
                if (c < line_dots && d_ld) begin
                    lds++;
                    if (first_ld < 0) first_ld = c;
                    else if (second_ld < 0) second_ld = c;
                end
                if (c == line_dots) chk("R3", "scan after one full line", int'(d_scan), 1);
            end
            chk("R3", "load strobes in one line", lds, VEC[i][3]);
            chk("R1", "dots between load strobes", second_ld - first_ld, VEC[i][2]);
        end

        // R10: reset mid-line, selects sampled while reset is held (R9)
        repeat (37) @(posedge clk);
        #1 rst = 1'b1; m_wide = 1'b0; m_slow = 1'b1;
        @(posedge clk); #1;
        chk("R10", "hsync in reset",      int'(d_hs),   0);
        chk("R10", "vsync in reset",      int'(d_vs),   0);
        chk("R10", "blank in reset",      int'(d_bl),   0);
        chk("R10", "load_stb in reset",   int'(d_ld),   0);
        chk("R10", "row in reset",        int'(d_row),  0);
        chk("R10", "scan in reset",       int'(d_scan), 0);
        chk("R10", "first_scan in reset", int'(d_fs),   1);
        chk("R10", "proc_clk in reset",   int'(d_pclk), 1);
        rst = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (c > 0) begin @(posedge clk); #1; end
            cmp(0, model(0, 0, 1, c, c));
        end

        // R5 R6 R7 R8 R9: whole frames on the reduced instance with mid-frame changes
        s_rst = 1'b1; s_wide = 1'b0; s_slow = 1'b0;
        @(posedge clk); @(posedge clk);
        #1 s_rst = 1'b0;
        held_w = 0; held_s = 0; fm_w = 0; fm_s = 0; fstart = 0;
        fetch_rises = 0; prev_fr = 1'b0;
        for (int t = 0; t < 1800; t++) begin
            if (t > 0) begin @(posedge clk); #1; end
            if (t - fstart == frame_len(1, fm_w, fm_s)) begin
                if (fstart == 0) chk("R8", "fetch requests in first frame", fetch_rises, 3);
                fstart = t; fm_w = held_w; fm_s = held_s;
            end
            cmp(1, model(1, fm_w, fm_s, t - fstart, t));
            if (s_fr && !prev_fr && fstart == 0) fetch_rises++;
            prev_fr = s_fr;
            if (t == 100)  begin held_w = 1; held_s = 1; s_wide = 1'b1; s_slow = 1'b1; end
            if (t == 500)  begin held_w = 0; held_s = 1; s_wide = 1'b0; s_slow = 1'b1; end
            if (t == 1000) begin held_w = 1; held_s = 0; s_wide = 1'b1; s_slow = 1'b0; end
            if (t == 359) chk("R9", "first frame keeps its length", int'(s_vs), 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule